// File: doc/BRIEF.md
# Audio Master Clock Generator

This block derives the three clocks of a stereo audio serial port from one interface clock: an oversampling master clock for an external converter, a serial bit clock, and a frame clock whose low half carries the left channel and whose high half carries the right. The interface clock runs at a fixed multiple of the sample rate, either 512 or 384, as chosen by a base-rate select input. A 3-bit code divides that clock by a power of two to form the master clock. A second select chooses a bit clock of 32 or 48 periods per sample. The 48 setting is the one used for 20-bit and 24-bit words.

A run input starts and stops the clocks. Every start begins a fresh frame with the left channel. When the block is strapped as a follower, it generates nothing. It holds its master clock low and forwards the bit and frame clocks supplied by a peer instance. Configuration is expected to be static while run is high. Sample rates from 8 kHz to 192 kHz are covered by choosing the interface clock accordingly.

Top module: `aclk_gen`

## Requirements
- R1: A frame lasts 512 interface cycles when base_lo is 0 and 384 cycles when base_lo is 1, so the frame clock rises once per frame.
- R2: With base_lo 0, div_code values 0, 1, 2, 3 and 4 give 512, 256, 128, 64 and 32 master-clock periods per frame.
- R3: With base_lo 1, div_code values 0, 1, 2 and 3 give 384, 192, 96 and 48 master-clock periods per frame.
- R4: An illegal div_code holds mclk_out low while the bit and frame clocks keep running. Illegal means a code above 4 with base_lo 0, or above 3 with base_lo 1.
- R5: For every legal code, mclk_out is high for exactly half of the time over a frame. Code 0 is the interface clock itself.
- R6: With bclk_fast 0, the bit clock completes 32 periods per frame.
- R7: With bclk_fast 1, the bit clock completes 48 periods per frame.
- R8: After run rises, the frame clock is low (left) until the rising edge numbered N/2 after the start, is high from that edge, and falls again at edge N. N is the frame length.
- R9: One cycle after run falls, mclk_out, bclk_out and fclk_out are all low.
- R10: With slave_sel 1, mclk_out is low and bclk_out and fclk_out follow ext_bclk and ext_fclk combinationally.
- R11: While rst_n is low, all three clock outputs are low, even with run high.
- R12: Every frame-clock edge coincides with a bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, 512x or 384x the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Clock generation enable |
| slave_sel | input | 1 | 1: forward peer clocks, generate none |
| base_lo | input | 1 | 0: interface clock is 512x fs, 1: 384x fs |
| div_code | input | 3 | Master-clock divider, divide by 2^div_code |
| bclk_fast | input | 1 | 0: 32 bit clocks per sample, 1: 48 |
| ext_bclk | input | 1 | Peer bit clock, used in slave mode |
| ext_fclk | input | 1 | Peer frame clock, used in slave mode |
| mclk_out | output | 1 | Oversampling master clock |
| bclk_out | output | 1 | Serial bit clock |
| fclk_out | output | 1 | Frame (left/right) clock |

## Verification
The registered bit clock, frame clock and divided master clock change one rising edge after the phase counter moves. In code 0 the master clock follows the interface clock through an enable that updates on the falling edge. Rate and duty checks therefore sample a quarter period after both edges over a window of exactly two frames, where edge counts do not depend on the starting phase. The start-of-frame checks count rising edges from the one that first sees run high and sample just after edges N/2-1, N/2 and N. Stop checks are made one full cycle after run falls. Slave pass-through is checked a moment after the peer clocks are driven.

// File: rtl/aclk_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the audio clock generator.
// Assumes the divider code is three bits wide and that the legal code
// limits are passed in by the instantiating module.
package aclk_pkg;

    localparam int DIV_CODE_W = 3;

    typedef logic [DIV_CODE_W-1:0] div_code_t;

    // True when the divider code is usable for the selected base ratio.
    function automatic logic code_ok(input logic lo_base, input div_code_t code,
                                     input int max_hi, input int max_lo);
        if (lo_base)
            return (int'(code) <= max_lo);
        else
            return (int'(code) <= max_hi);
    endfunction

endpackage

// File: rtl/aclk_phase_ctr.sv
`timescale 1ns/1ps
// Frame phase counter and frame clock.
// Counts interface cycles within one frame (HI_LEN or LO_LEN long) and drives
// the frame clock low in the first half and high in the second half.
// Assumes base_lo is stable while active is high.
module aclk_phase_ctr #(
    parameter int HI_LEN = 512,
    parameter int LO_LEN = 384,
    localparam int PH_W  = $clog2(HI_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            base_lo,
    output logic [PH_W-1:0] phase,
    output logic [PH_W-1:0] phase_nxt,
    output logic            fclk_q
);

    logic [PH_W:0] frame_len;
    logic [PH_W:0] half_len;

    // Frame length and mid-point for the selected base ratio.
    always_comb begin
        frame_len = base_lo ? (PH_W+1)'(LO_LEN) : (PH_W+1)'(HI_LEN);
        half_len  = frame_len >> 1;
    end

    // Next phase: wrap at frame end, return to zero when stopped.
    always_comb begin
        if (!active)
            phase_nxt = '0;
        else if ({1'b0, phase} == frame_len - 1'b1)
            phase_nxt = '0;
        else
            phase_nxt = phase + 1'b1;
    end

    // Phase register and frame clock; high while the new phase is in the second half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= '0;
            fclk_q <= 1'b0;
        end else begin
            phase  <= phase_nxt;
            fclk_q <= active && ({1'b0, phase_nxt} >= half_len);
        end
    end

    a_r1_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, phase} < frame_len));

    a_r1_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> (phase == '0 || phase == $past(phase) + 1'b1));

    a_r8_fclk_rise_midframe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fclk_q) |-> ({1'b0, phase} == half_len));

    a_r8_fclk_fall_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fclk_q) && active) |-> (phase == '0));

endmodule

// File: rtl/aclk_bclk_gen.sv
`timescale 1ns/1ps
// Bit clock generator.
// A phase accumulator adds twice the bit-clock rate every interface cycle and
// toggles the bit clock on each wrap past the frame length, which yields an
// exact count of bit-clock periods per frame even when the ratio is fractional.
// Assumes 2*FAST_RATE < LO_LEN and configuration stable while active.
module aclk_bclk_gen #(
    parameter int HI_LEN    = 512,
    parameter int LO_LEN    = 384,
    parameter int SLOW_RATE = 32,
    parameter int FAST_RATE = 48,
    localparam int ACC_W    = $clog2(HI_LEN) + 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic base_lo,
    input  logic fast,
    output logic bclk_q
);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] frame_len;
    logic [ACC_W-1:0] sum;

    // Accumulator increment, modulus and raw sum.
    always_comb begin
        step      = fast ? ACC_W'(2 * FAST_RATE) : ACC_W'(2 * SLOW_RATE);
        frame_len = base_lo ? ACC_W'(LO_LEN) : ACC_W'(HI_LEN);
        sum       = acc + step;
    end

    // Accumulate and toggle the bit clock on each modulus crossing.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            acc    <= '0;
            bclk_q <= 1'b0;
        end else if (sum >= frame_len) begin
            acc    <= sum - frame_len;
            bclk_q <= ~bclk_q;
        end else begin
            acc    <= sum;
        end
    end

    a_r7_acc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (acc < frame_len));

    a_r9_bclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !bclk_q);

endmodule

// File: rtl/aclk_mclk_gen.sv
`timescale 1ns/1ps
// Master clock generator.
// Codes 1..MAX_HI select a bit of the next frame phase, giving a registered
// divide-by-2^code clock. Code 0 passes the interface clock through an AND gate
// whose enable is updated on the falling edge, so the gate never opens or
// closes while the clock is high. Illegal codes keep the output low.
module aclk_mclk_gen
    import aclk_pkg::*;
#(
    parameter int PH_W   = 9,
    parameter int MAX_HI = 4,
    parameter int MAX_LO = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            base_lo,
    input  div_code_t       div_code,
    input  logic [PH_W-1:0] phase_nxt,
    output logic            mclk_out
);

    logic legal;
    logic div_sel;
    logic mclk_q;
    logic pass_en;

    // Code legality for the selected base ratio.
    always_comb legal = code_ok(base_lo, div_code, MAX_HI, MAX_LO);

    // Pick the phase bit that toggles at the requested division.
    always_comb begin
        div_sel = 1'b0;
        for (int k = 1; k <= MAX_HI; k++) begin
            if (div_code == DIV_CODE_W'(k))
                div_sel = phase_nxt[k-1];
        end
    end

    // Registered divided clock for codes other than zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mclk_q <= 1'b0;
        else
            mclk_q <= active && legal && (div_code != '0) && div_sel;
    end

    // Pass-through enable, changed only while the clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n)
            pass_en <= 1'b0;
        else
            pass_en <= active && legal && (div_code == '0);
    end

    always_comb mclk_out = mclk_q | (clk & pass_en);

    a_r4_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!legal) |=> !mclk_q);

    a_r5_half_rate_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && active && div_code == DIV_CODE_W'(1)) |=> (mclk_q != $past(mclk_q)));

    a_r2_div_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mclk_q && pass_en));

endmodule

// File: rtl/aclk_gen.sv
`timescale 1ns/1ps
// Audio clock generator top.
// Builds master, bit and frame clocks from an interface clock at 512x or 384x
// the sample rate. In slave mode the internal generators are held stopped and
// the peer's bit and frame clocks are forwarded. Configuration inputs must be
// held stable while run is high.
module aclk_gen #(
    parameter int HI_LEN    = 512,
    parameter int LO_LEN    = 384,
    parameter int SLOW_RATE = 32,
    parameter int FAST_RATE = 48,
    parameter int MAX_HI    = 4,
    parameter int MAX_LO    = 3,
    localparam int PH_W     = $clog2(HI_LEN)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       slave_sel,
    input  logic       base_lo,
    input  logic [2:0] div_code,
    input  logic       bclk_fast,
    input  logic       ext_bclk,
    input  logic       ext_fclk,
    output logic       mclk_out,
    output logic       bclk_out,
    output logic       fclk_out
);

    logic            active;
    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] phase_nxt;
    logic            fclk_q;
    logic            bclk_q;
    logic            mclk_int;

    // Generators run only when enabled and not following a peer.
    always_comb active = run && !slave_sel;

    aclk_phase_ctr #(
        .HI_LEN (HI_LEN),
        .LO_LEN (LO_LEN)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .base_lo   (base_lo),
        .phase     (phase),
        .phase_nxt (phase_nxt),
        .fclk_q    (fclk_q)
    );

    aclk_bclk_gen #(
        .HI_LEN    (HI_LEN),
        .LO_LEN    (LO_LEN),
        .SLOW_RATE (SLOW_RATE),
        .FAST_RATE (FAST_RATE)
    ) u_bclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .base_lo (base_lo),
        .fast    (bclk_fast),
        .bclk_q  (bclk_q)
    );

    aclk_mclk_gen #(
        .PH_W   (PH_W),
        .MAX_HI (MAX_HI),
        .MAX_LO (MAX_LO)
    ) u_mclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .base_lo   (base_lo),
        .div_code  (div_code),
        .phase_nxt (phase_nxt),
        .mclk_out  (mclk_int)
    );

    // Output selection between own clocks and the peer's.
    always_comb begin
        mclk_out = slave_sel ? 1'b0 : mclk_int;
        bclk_out = slave_sel ? ext_bclk : bclk_q;
        fclk_out = slave_sel ? ext_fclk : fclk_q;
    end

    a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!bclk_q && !fclk_q));

    a_r12_frame_edge_on_bclk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fclk_q) |-> !$stable(bclk_q));

    a_r1_phase_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (phase == '0));

endmodule

// File: tb/aclk_gen_tb.sv
`timescale 1ns/1ps
module aclk_gen_tb;

    localparam int CLK_PERIOD = 8;
    localparam int QTR        = CLK_PERIOD / 4;
    localparam int MAX_CYCLES = 150000;

    typedef struct packed {
        logic       lo;
        logic [2:0] code;
        logic       fast;
        logic [9:0] mclk_pf;
        logic [7:0] bclk_pf;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd0, 1'b0, 10'd512, 8'd32},
        '{1'b0, 3'd1, 1'b1, 10'd256, 8'd48},
        '{1'b0, 3'd2, 1'b0, 10'd128, 8'd32},
        '{1'b0, 3'd3, 1'b1, 10'd64,  8'd48},
        '{1'b0, 3'd4, 1'b0, 10'd32,  8'd32},
        '{1'b0, 3'd5, 1'b1, 10'd0,   8'd48},
        '{1'b1, 3'd0, 1'b1, 10'd384, 8'd48},
        '{1'b1, 3'd1, 1'b0, 10'd192, 8'd32},
        '{1'b1, 3'd2, 1'b1, 10'd96,  8'd48},
        '{1'b1, 3'd3, 1'b0, 10'd48,  8'd32},
        '{1'b1, 3'd4, 1'b1, 10'd0,   8'd48},
        '{1'b0, 3'd7, 1'b0, 10'd0,   8'd32}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       slave_sel = 1'b0;
    logic       base_lo = 1'b0;
    logic [2:0] div_code = 3'd0;
    logic       bclk_fast = 1'b0;
    logic       ext_bclk = 1'b0;
    logic       ext_fclk = 1'b0;
    logic       mclk_out, bclk_out, fclk_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    aclk_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .slave_sel (slave_sel),
        .base_lo   (base_lo),
        .div_code  (div_code),
        .bclk_fast (bclk_fast),
        .ext_bclk  (ext_bclk),
        .ext_fclk  (ext_fclk),
        .mclk_out  (mclk_out),
        .bclk_out  (bclk_out),
        .fclk_out  (fclk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait for a rising edge and move a quarter period past it.
    task automatic after_pos();
        @(posedge clk);
        #QTR;
    endtask

    // Count rising edges and high samples over exactly two frames, two samples per cycle.
    task automatic measure(input int len, output int mr, output int mh,
                           output int br, output int fr);
        logic pm, pb, pf;
        mr = 0; mh = 0; br = 0; fr = 0;
        after_pos();
        pm = mclk_out; pb = bclk_out; pf = fclk_out;
        for (int i = 0; i < 4 * len; i++) begin
            if (i % 2 == 0) @(negedge clk);
            else            @(posedge clk);
            #QTR;
            if (mclk_out && !pm) mr++;
            if (mclk_out)        mh++;
            if (bclk_out && !pb) br++;
            if (fclk_out && !pf) fr++;
            pm = mclk_out; pb = bclk_out; pf = fclk_out;
        end
    endtask

    // Start from stop and check the frame clock and bit clock around mid-frame.
    task automatic start_check(input logic lo);
        int  len;
        logic b_before;
        len = lo ? 384 : 512;
        run = 1'b0; base_lo = lo; div_code = 3'd2; bclk_fast = lo;
        repeat (3) after_pos();
        run = 1'b1;
        for (int j = 1; j <= len; j++) begin
            after_pos();
            if (j == 1)
                check(fclk_out == 1'b0, "R8 left first after start", fclk_out, 0);
            if (j == len / 2 - 1) begin
                check(fclk_out == 1'b0, "R8 still left before mid-frame", fclk_out, 0);
                b_before = bclk_out;
            end
            if (j == len / 2) begin
                check(fclk_out == 1'b1, "R8 right from mid-frame", fclk_out, 1);
                check(bclk_out != b_before, "R12 bit clock edge at frame edge",
                      bclk_out, !b_before);
            end
            if (j == len)
                check(fclk_out == 1'b0, "R8 left again at frame wrap", fclk_out, 0);
        end
        run = 1'b0;
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", MAX_CYCLES, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int mr, mh, br, fr, len;
        string mreq;

        // R11: reset dominates a requested run in pass-through mode.
        run = 1'b1; div_code = 3'd0;
        repeat (4) after_pos();
        check(mclk_out == 1'b0, "R11 mclk low in reset", mclk_out, 0);
        check(bclk_out == 1'b0, "R11 bclk low in reset", bclk_out, 0);
        check(fclk_out == 1'b0, "R11 fclk low in reset", fclk_out, 0);
        run = 1'b0;
        after_pos();
        rst_n = 1'b1;
        repeat (2) after_pos();

        // Vector table walk: rates, duty and legality (R1..R7).
        for (int v = 0; v < NVEC; v++) begin
            run = 1'b0;
            repeat (2) after_pos();
            base_lo = VECS[v].lo; div_code = VECS[v].code; bclk_fast = VECS[v].fast;
            run = 1'b1;
            repeat (5) after_pos();
            len = VECS[v].lo ? 384 : 512;
            measure(len, mr, mh, br, fr);
            if (VECS[v].mclk_pf == 0) mreq = "R4 illegal code master clock";
            else if (VECS[v].lo)     mreq = "R3 master clock ratio 384 base";
            else                     mreq = "R2 master clock ratio 512 base";
            check(mr == 2 * int'(VECS[v].mclk_pf), mreq, mr, 2 * int'(VECS[v].mclk_pf));
            if (VECS[v].mclk_pf == 0)
                check(mh == 0, "R4 illegal code holds low", mh, 0);
            else
                check(mh == 2 * len, "R5 master clock duty", mh, 2 * len);
            check(br == 2 * int'(VECS[v].bclk_pf),
                  VECS[v].fast ? "R7 bit clock 48 per frame" : "R6 bit clock 32 per frame",
                  br, 2 * int'(VECS[v].bclk_pf));
            check(fr == 2, "R1 one frame clock rise per frame", fr, 2);
        end
        run = 1'b0;

        // R8 and R12 at both base ratios.
        start_check(1'b0);
        start_check(1'b1);

        // R9: stop in pass-through mode, outputs low one cycle later.
        base_lo = 1'b0; div_code = 3'd0; bclk_fast = 1'b0;
        run = 1'b1;
        repeat (300) after_pos();
        run = 1'b0;
        after_pos();
        check(mclk_out == 1'b0, "R9 mclk low after stop", mclk_out, 0);
        check(bclk_out == 1'b0, "R9 bclk low after stop", bclk_out, 0);
        check(fclk_out == 1'b0, "R9 fclk low after stop", fclk_out, 0);

        // R10: slave mode forwards peer clocks and generates no master clock.
        slave_sel = 1'b1; run = 1'b1;
        repeat (3) after_pos();
        ext_bclk = 1'b1; ext_fclk = 1'b0;
        #1;
        check(bclk_out == 1'b1, "R10 bclk follows peer", bclk_out, 1);
        check(fclk_out == 1'b0, "R10 fclk follows peer", fclk_out, 0);
        ext_bclk = 1'b0; ext_fclk = 1'b1;
        #1;
        check(bclk_out == 1'b0, "R10 bclk follows peer", bclk_out, 0);
        check(fclk_out == 1'b1, "R10 fclk follows peer", fclk_out, 1);
        measure(64, mr, mh, br, fr);
        check(mh == 0, "R10 no master clock in slave mode", mh, 0);
        slave_sel = 1'b0; run = 1'b0;
        after_pos();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule